// File: doc/BRIEF.md
# Packed Zero-Lane Index Finder

This block looks at a 64-bit operand as a row of equal-width lanes and reports where the first all-zero lane sits. The lanes are either eight bytes or four 16-bit halfwords. Software-visible string and vector routines use a result like this to find a terminator or an empty slot in one step, without a loop over the lanes.

Two run-time controls set the behaviour. One picks the lane width. The other picks the scan direction: downward from the most significant lane, or upward from the least significant lane. The index returned is the position along the chosen scan order, so index 0 is always the first lane the scan looks at. When no lane is zero, the result is the lane count for the chosen width.

By default, a single register stage with a valid flag sits on the output. A parameter can remove that stage and leave a purely combinational path.

Top module: `zidx_finder`

## Requirements
- R1: With `laneWide`=0 the operand is split into eight byte lanes, and a zero byte produces an index in the range 0 to 7.
- R2: With `laneWide`=0 and no byte equal to zero, `outIndex` is 8.
- R3: With `laneWide`=1 the operand is split into four halfword lanes, `outIndex` never exceeds 4, and a zero byte inside a non-zero halfword is not counted as a zero lane.
- R4: With `laneWide`=1 and no halfword equal to zero, `outIndex` is 4.
- R5: With `scanFromLow`=0 the scan starts at the most significant lane, and that lane has index 0 (byte bits 63:56, halfword bits 63:48).
- R6: With `scanFromLow`=1 the scan starts at the least significant lane, and that lane has index 0 (byte bits 7:0, halfword bits 15:0).
- R7: When several lanes are zero, only the first one in scan order sets the result.
- R8: With the default register stage, `outValid` equals `inValid` of the previous cycle, and `outIndex` shows the result for that cycle's operand. A cycle with `inValid`=0 leaves `outIndex` unchanged.
- R9: While `rstN` is low, `outValid` is 0 and `outIndex` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand and controls are valid this cycle |
| inData | input | 64 | Operand to scan |
| laneWide | input | 1 | 0: byte lanes, 1: halfword lanes |
| scanFromLow | input | 1 | 0: scan from most significant lane, 1: scan from least significant lane |
| outValid | output | 1 | Result is valid |
| outIndex | output | 4 | Scan position of the first zero lane, or the lane count if none |

## Verification
The bench drives a zero lane at every position under both widths and both directions. A design that numbers lanes by bit position instead of scan position gives mirrored indices when scanning from the top. Operands with several zero lanes catch an encoder that lets the last match win instead of the first. Halfwords that hold exactly one zero byte, and operands with no zero lane at all, expose a wide mode that tests bytes or that returns 8 instead of 4. Idle cycles between valid operands show whether the output register wrongly loads when no operand is valid.

// File: rtl/zidx_pkg.sv
package zidx_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic wideLanes;  // halfword lanes selected
    logic scanUp;     // scan starts at the least significant lane
    logic capture;    // load the output register this cycle
  } scanCtrl_t;

endpackage

// File: rtl/zidx_ctrl.sv
module zidx_ctrl
  import zidx_pkg::*;
#(
  parameter int PIPELINE = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      laneWide,
  input  logic      scanFromLow,
  output scanCtrl_t ctrl,
  output logic      outValid
);

  always_comb begin
    ctrl.wideLanes = laneWide;
    ctrl.scanUp    = scanFromLow;
    ctrl.capture   = inValid;
  end

  generate
    if (PIPELINE != 0) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid & rstN;
    end
  endgenerate

endmodule

// File: rtl/zidx_datapath.sv
module zidx_datapath
  import zidx_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16,
  parameter int PIPELINE = 1,
  localparam int NL      = DATA_W / NARROW_W,
  localparam int WL      = DATA_W / WIDE_W,
  localparam int RATIO   = WIDE_W / NARROW_W,
  localparam int IDX_W   = $clog2(NL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  scanCtrl_t         ctrl,
  output logic [IDX_W-1:0]  outIndex
);

  logic [NL-1:0]    byteZero;
  logic [WL-1:0]    halfZero;
  logic [NL-1:0]    orderNarrow;
  logic [WL-1:0]    orderWide;
  logic [NL-1:0]    ordered;
  logic [IDX_W-1:0] laneCount;
  logic [IDX_W-1:0] firstPos;

  // A byte lane is zero when all of its bits are low.
  for (genvar b = 0; b < NL; b++) begin : g_byte
    assign byteZero[b] = ~|inData[b*NARROW_W +: NARROW_W];
  end

  // A halfword lane is zero only when every byte inside it is zero.
  for (genvar h = 0; h < WL; h++) begin : g_half
    assign halfZero[h] = &byteZero[h*RATIO +: RATIO];
  end

  // Put the lane flags in scan order, so that bit 0 is the first lane looked at.
  for (genvar k = 0; k < NL; k++) begin : g_ordN
    assign orderNarrow[k] = ctrl.scanUp ? byteZero[k] : byteZero[NL-1-k];
  end
  for (genvar k = 0; k < WL; k++) begin : g_ordW
    assign orderWide[k] = ctrl.scanUp ? halfZero[k] : halfZero[WL-1-k];
  end

  assign ordered   = ctrl.wideLanes ? NL'(orderWide) : orderNarrow;
  assign laneCount = ctrl.wideLanes ? IDX_W'(WL) : IDX_W'(NL);

  // The lowest set flag in scan order wins. With no flag set, the lane count is returned.
  always_comb begin
    firstPos = laneCount;
    for (int k = NL - 1; k >= 0; k--) begin
      if (ordered[k]) firstPos = IDX_W'(k);
    end
  end

  generate
    if (PIPELINE != 0) begin : g_reg
      logic [IDX_W-1:0] idxQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            idxQ <= '0;
        else if (ctrl.capture) idxQ <= firstPos;
      end
      assign outIndex = idxQ;
    end else begin : g_comb
      assign outIndex = rstN ? firstPos : '0;
    end
  endgenerate

endmodule

// File: rtl/zidx_finder.sv
module zidx_finder
  import zidx_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16,
  parameter int PIPELINE = 1
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   inValid,
  input  logic [DATA_W-1:0]                      inData,
  input  logic                                   laneWide,
  input  logic                                   scanFromLow,
  output logic                                   outValid,
  output logic [$clog2(DATA_W/NARROW_W+1)-1:0]   outIndex
);

  scanCtrl_t ctrl;

  zidx_ctrl #(.PIPELINE(PIPELINE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .laneWide   (laneWide),
    .scanFromLow(scanFromLow),
    .ctrl       (ctrl),
    .outValid   (outValid)
  );

  zidx_datapath #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .WIDE_W  (WIDE_W),
    .PIPELINE(PIPELINE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .ctrl    (ctrl),
    .outIndex(outIndex)
  );

endmodule

// File: rtl/zidx_finder_chk.sv
module zidx_finder_chk #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 8,
  parameter int WIDE_W   = 16,
  parameter int PIPELINE = 1,
  localparam int NL      = DATA_W / NARROW_W,
  localparam int WL      = DATA_W / WIDE_W,
  localparam int IDX_W   = $clog2(NL + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              laneWide,
  input logic              scanFromLow,
  input logic              outValid,
  input logic [IDX_W-1:0]  outIndex
);

  logic anyByteZero;
  logic anyHalfZero;

  always_comb begin
    anyByteZero = 1'b0;
    anyHalfZero = 1'b0;
    for (int i = 0; i < NL; i++)
      if (inData[i*NARROW_W +: NARROW_W] == '0) anyByteZero = 1'b1;
    for (int i = 0; i < WL; i++)
      if (inData[i*WIDE_W +: WIDE_W] == '0) anyHalfZero = 1'b1;
  end

  // R9: reset state
  always @(negedge clk) begin
    if (!rstN) begin
      a_r9_reset_state: assert (!outValid && outIndex == '0);
    end
  end

  generate
    if (PIPELINE != 0) begin : g_seq
      a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(outIndex));
      a_r2_byte_default: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !laneWide && !anyByteZero) |=> outIndex == IDX_W'(NL));
      a_r4_half_default: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && laneWide && !anyHalfZero) |=> outIndex == IDX_W'(WL));
      a_r3_half_range: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && laneWide) |=> outIndex <= IDX_W'(WL));
      a_r1_byte_found: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !laneWide && anyByteZero) |=> outIndex < IDX_W'(NL));
      a_r5_top_first: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !laneWide && !scanFromLow && inData[DATA_W-1 -: NARROW_W] == '0)
        |=> outIndex == '0);
      a_r6_bottom_first: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !laneWide && scanFromLow && inData[NARROW_W-1:0] == '0)
        |=> outIndex == '0);
    end
  endgenerate

endmodule

bind zidx_finder zidx_finder_chk #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W),
  .WIDE_W  (WIDE_W),
  .PIPELINE(PIPELINE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inData     (inData),
  .laneWide   (laneWide),
  .scanFromLow(scanFromLow),
  .outValid   (outValid),
  .outIndex   (outIndex)
);

// File: tb/zidx_finder_tb.sv
`timescale 1ns/1ps
module zidx_finder_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [63:0] inData;
  logic        laneWide;
  logic        scanFromLow;
  logic        outValid;
  logic [3:0]  outIndex;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit       expValid;
  int       expIdx;

  always #2.5 clk = ~clk;

  zidx_finder u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inData     (inData),
    .laneWide   (laneWide),
    .scanFromLow(scanFromLow),
    .outValid   (outValid),
    .outIndex   (outIndex)
  );

  function automatic int refIndex(logic [63:0] d, bit wide, bit low);
    int lanes = wide ? 4 : 8;
    int w     = wide ? 16 : 8;
    for (int p = 0; p < lanes; p++) begin
      int lane = low ? p : lanes - 1 - p;
      logic [63:0] field = (d >> (lane * w)) & ((64'd1 << w) - 64'd1);
      if (field == 64'd0) return p;
    end
    return lanes;
  endfunction

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, then compare at the next falling edge.
  task automatic step(logic [63:0] d, bit wide, bit low, bit vld, string req);
    inData      = d;
    laneWide    = wide;
    scanFromLow = low;
    inValid     = vld;
    if (vld) expIdx = refIndex(d, wide, low);
    expValid = vld;
    @(negedge clk);
    checkVal(req, "outValid", int'(outValid), int'(expValid));
    checkVal(req, "outIndex", int'(outIndex), expIdx);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inData = '0; laneWide = 1'b0; scanFromLow = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R9", "outValid", int'(outValid), 0);
    checkVal("R9", "outIndex", int'(outIndex), 0);
    rstN = 1'b1;
    expValid = 1'b0; expIdx = 0;
    @(negedge clk);

    // R1 R5 R6: single zero byte at every position, both directions
    for (int pos = 0; pos < 8; pos++) begin
      logic [63:0] d = 64'h1111_1111_1111_1111 & ~(64'hFF << (pos * 8));
      step(d, 1'b0, 1'b0, 1'b1, "R5");
      step(d, 1'b0, 1'b1, 1'b1, "R6");
    end
    // R2: no zero byte
    step(64'h0102_0304_0506_0708, 1'b0, 1'b0, 1'b1, "R2");
    step(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, "R2");
    // R3: zero halfword at every position, both directions
    for (int pos = 0; pos < 4; pos++) begin
      logic [63:0] d = 64'hABCD_ABCD_ABCD_ABCD & ~(64'hFFFF << (pos * 16));
      step(d, 1'b1, 1'b0, 1'b1, "R3");
      step(d, 1'b1, 1'b1, 1'b1, "R3");
    end
    // R3 R4: zero bytes only inside non-zero halfwords
    step(64'h0100_0001_1200_0034, 1'b1, 1'b0, 1'b1, "R4");
    step(64'h0100_0001_1200_0034, 1'b1, 1'b1, 1'b1, "R4");
    step(64'h0100_0001_1200_0034, 1'b0, 1'b1, 1'b1, "R1");
    // R7: several zero lanes
    step(64'h0011_0022_0000_3300, 1'b0, 1'b0, 1'b1, "R7");
    step(64'h0011_0022_0000_3300, 1'b0, 1'b1, 1'b1, "R7");
    step(64'h0000_1234_0000_0000, 1'b1, 1'b0, 1'b1, "R7");
    step(64'h0000_1234_0000_0000, 1'b1, 1'b1, 1'b1, "R7");
    step(64'h0, 1'b0, 1'b1, 1'b1, "R7");
    step(64'h0, 1'b1, 1'b0, 1'b1, "R7");
    // R8: idle cycles must not disturb the held index
    step(64'h1111_1111_1111_0011, 1'b0, 1'b1, 1'b1, "R8");
    step(64'h0, 1'b1, 1'b0, 1'b0, "R8");
    step(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, "R8");
    step(64'h0000_1111_1111_1111, 1'b0, 1'b0, 1'b1, "R8");

    // R1: random operands with frequent zero lanes, mixed modes
    for (int n = 0; n < 400; n++) begin
      logic [63:0] d;
      for (int b = 0; b < 8; b++)
        d[b*8 +: 8] = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(1, 255));
      step(d, 1'($urandom), 1'($urandom), ($urandom_range(0, 4) != 0), "R1");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule